// File: doc/BRIEF.md
# Descriptor Condition Evaluator

This unit judges, for the descriptor a DMA channel is executing, three separate questions: should the channel raise an interrupt, should it jump to the descriptor's alternate address instead of stepping to the next one, and should it stall in a wait. Each question has its own 2-bit policy in the command word and its own select register. A select register carries a 4-bit mask and a 4-bit compare value. The condition for a question is true when the low device-status bits, under that mask, equal the compare value under the same mask.

The sequencer that owns descriptor fetch pulses `eval_i` for one cycle with the command bits, the three select registers and the device status presented. In that cycle the three decision outputs carry the verdicts. At every other time they are held low. A stall verdict takes precedence, so a descriptor that waits neither interrupts nor branches in that evaluation. An interrupt verdict also sets a registered interrupt level. That level stays high until the interrupt handler acknowledges it.

Top module: `cond_eval`

## Requirements
- R1: The command control input holds three policies: bits 5:4 govern the interrupt, bits 3:2 govern the branch, and bits 1:0 govern the wait.
- R2: Each policy codes 0 as never, 1 as taken when the condition is true, 2 as taken when the condition is false, and 3 as always.
- R3: In each select register, only the mask in bits 19:16 and the compare value in bits 3:0 count. All other bits have no effect on any decision.
- R4: A condition is true exactly when (status[3:0] & mask) == (value & mask). Device-status bits above bit 3 have no effect.
- R5: The interrupt decision uses only the interrupt select register. The branch decision uses only the branch select register. The wait decision uses only the wait select register.
- R6: When a select register's mask is zero, its condition is true, so policy 1 is taken and policy 2 is not.
- R7: All three decision outputs are low in any cycle where `eval_i` is low.
- R8: When the wait decision is high, the interrupt and branch decisions are forced low in that same cycle.
- R9: After a cycle with the interrupt decision high, `irq_o` is high. It stays high until a cycle with `irq_ack_i` high and no interrupt decision, after which it is low.
- R10: When the interrupt decision and `irq_ack_i` are both high in one cycle, `irq_o` is high afterwards.
- R11: While `rst_ni` is low, `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| eval_i | input | 1 | One-cycle strobe that asks for a verdict |
| ctl_i | input | 6 | Policy bits of the command word |
| irq_sel_i | input | 32 | Interrupt select register (mask 19:16, value 3:0) |
| br_sel_i | input | 32 | Branch select register (mask 19:16, value 3:0) |
| wait_sel_i | input | 32 | Wait select register (mask 19:16, value 3:0) |
| dev_stat_i | input | 8 | Device-status bits of the channel |
| irq_ack_i | input | 1 | Clears the interrupt level |
| irq_take_o | output | 1 | Interrupt verdict, valid with eval_i |
| branch_o | output | 1 | Branch verdict, valid with eval_i |
| wait_o | output | 1 | Stall verdict, valid with eval_i |
| irq_o | output | 1 | Registered interrupt request level |

## Verification
Two pairs of functions can fall in the same cycle. The first is a stall verdict against an interrupt or branch verdict that it must suppress. The second is a fresh interrupt verdict against an acknowledge that would clear the level. The bench sweeps every combination of the six policy bits and every low device-status value against a family of select registers whose masks and values differ per register. It raises the acknowledge on a pattern independent of the verdict, so both collisions occur many times. A reference model predicts each verdict and the interrupt level cycle by cycle and compares them.

// File: rtl/cond_eval_pkg.sv
package cond_eval_pkg;

    // Policy code carried in each 2-bit field of the command word
    typedef enum logic [1:0] {
        POL_NEVER    = 2'd0,
        POL_IF_MATCH = 2'd1,
        POL_IF_MISS  = 2'd2,
        POL_ALWAYS   = 2'd3
    } policy_e;

    // Field index: policy g sits at command bits [2g+1:2g]
    localparam int IDX_WAIT = 0;
    localparam int IDX_BR   = 1;
    localparam int IDX_IRQ  = 2;
    localparam int NUM_POL  = 3;
    localparam int POL_W    = 2;

    typedef struct packed {
        logic irq;
    } irq_state_t;

    typedef struct packed {
        logic irq;
        logic br;
        logic wt;
    } verdict_t;

endpackage

// File: rtl/cond_match.sv
module cond_match #(
    parameter int COND_W = 4
) (
    input  logic [COND_W-1:0] stat_i,
    input  logic [COND_W-1:0] mask_i,
    input  logic [COND_W-1:0] value_i,
    output logic              hit_o
);
    // Masked compare; an all-zero mask always matches
    always_comb begin
        hit_o = ((stat_i & mask_i) == (value_i & mask_i));
    end
endmodule

// File: rtl/cond_policy.sv
module cond_policy
    import cond_eval_pkg::*;
(
    input  policy_e pol_i,
    input  logic    hit_i,
    output logic    take_o
);
    always_comb begin
        unique case (pol_i)
            POL_NEVER:    take_o = 1'b0;
            POL_IF_MATCH: take_o = hit_i;
            POL_IF_MISS:  take_o = !hit_i;
            POL_ALWAYS:   take_o = 1'b1;
            default:      take_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/cond_eval.sv
module cond_eval
    import cond_eval_pkg::*;
#(
    parameter int STAT_W  = 8,
    parameter int SEL_W   = 32,
    parameter int COND_W  = 4,
    parameter int MASK_LO = 16
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     eval_i,
    input  logic [NUM_POL*POL_W-1:0] ctl_i,
    input  logic [SEL_W-1:0]         irq_sel_i,
    input  logic [SEL_W-1:0]         br_sel_i,
    input  logic [SEL_W-1:0]         wait_sel_i,
    input  logic [STAT_W-1:0]        dev_stat_i,
    input  logic                     irq_ack_i,
    output logic                     irq_take_o,
    output logic                     branch_o,
    output logic                     wait_o,
    output logic                     irq_o
);
    localparam int MASK_HI = MASK_LO + COND_W - 1;

    logic [SEL_W-1:0]  sel_arr [NUM_POL];
    logic [NUM_POL-1:0] hit;
    logic [NUM_POL-1:0] raw_take;
    logic [COND_W-1:0]  stat_low;

    assign sel_arr[IDX_WAIT] = wait_sel_i;
    assign sel_arr[IDX_BR]   = br_sel_i;
    assign sel_arr[IDX_IRQ]  = irq_sel_i;
    assign stat_low          = dev_stat_i[COND_W-1:0];

    // One matcher and one policy decoder per decision, each on its own select
    for (genvar g = 0; g < NUM_POL; g++) begin : g_pol
        cond_match #(.COND_W(COND_W)) i_match (
            .stat_i  (stat_low),
            .mask_i  (sel_arr[g][MASK_HI:MASK_LO]),
            .value_i (sel_arr[g][COND_W-1:0]),
            .hit_o   (hit[g])
        );
        cond_policy i_policy (
            .pol_i   (policy_e'(ctl_i[g*POL_W +: POL_W])),
            .hit_i   (hit[g]),
            .take_o  (raw_take[g])
        );
    end

    // Bits of the select registers and status outside the used fields
    logic unused_bits;
    assign unused_bits = ^{dev_stat_i, irq_sel_i, br_sel_i, wait_sel_i};

    irq_state_t st_d, st_q;
    verdict_t   vd;

    always_comb begin
        vd    = '0;
        st_d  = st_q;
        if (eval_i) begin
            vd.wt  = raw_take[IDX_WAIT];
            vd.br  = raw_take[IDX_BR]  && !raw_take[IDX_WAIT];
            vd.irq = raw_take[IDX_IRQ] && !raw_take[IDX_WAIT];
        end
        if (irq_ack_i) st_d.irq = 1'b0;
        if (vd.irq)    st_d.irq = 1'b1;   // new request beats acknowledge
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign irq_take_o = vd.irq;
    assign branch_o   = vd.br;
    assign wait_o     = vd.wt;
    assign irq_o      = st_q.irq;

    // ---------------- assertions ----------------
    assert_idle_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !eval_i |-> (!irq_take_o && !branch_o && !wait_o));

    assert_wait_blocks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wait_o |-> (!irq_take_o && !branch_o));

    assert_never_wait_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctl_i[1:0] == 2'd0) |-> !wait_o);

    assert_always_wait_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (eval_i && ctl_i[1:0] == 2'd3) |-> wait_o);

    assert_zero_mask_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (eval_i && wait_sel_i[MASK_HI:MASK_LO] == '0 && ctl_i[1:0] == 2'd2) |-> !wait_o);

    assert_irq_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_take_o |=> irq_o);

    assert_irq_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_ack_i && !irq_take_o) |=> !irq_o);

    assert_irq_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!irq_ack_i && !irq_take_o) |=> $stable(irq_o));

    assert_set_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_ack_i && irq_take_o) |=> irq_o);

    always_ff @(posedge clk_i) begin
        if (!rst_ni) assert_reset_low_R11: assert (!irq_o);
    end

endmodule

// File: tb/test_cond_eval.sv
`timescale 1ns/1ps
module test_cond_eval;
    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        eval_i = 1'b0;
    logic [5:0]  ctl_i = '0;
    logic [31:0] irq_sel_i = '0, br_sel_i = '0, wait_sel_i = '0;
    logic [7:0]  dev_stat_i = '0;
    logic        irq_ack_i = 1'b0;
    logic        irq_take_o, branch_o, wait_o, irq_o;

    int vectors = 0;
    int errors  = 0;
    logic irq_exp = 1'b0;

    always #5 clk_i = ~clk_i;

    cond_eval i_cond_eval (
        .clk_i, .rst_ni, .eval_i, .ctl_i, .irq_sel_i, .br_sel_i, .wait_sel_i,
        .dev_stat_i, .irq_ack_i, .irq_take_o, .branch_o, .wait_o, .irq_o
    );

    // Reference model. R4: (stat & mask) == (value & mask), mask 19:16, value 3:0 (R3)
    function automatic logic cond_of(input logic [7:0] st, input logic [31:0] sel);
        return ((st[3:0] & sel[19:16]) == (sel[3:0] & sel[19:16]));
    endfunction

    // R2: 0 never, 1 if true, 2 if false, 3 always
    function automatic logic pol_of(input logic [1:0] p, input logic c);
        return (p == 2'd3) || (p == 2'd1 && c) || (p == 2'd2 && !c);
    endfunction

    task automatic check(input logic act, input logic exp, input string tag, input string what);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    // One evaluation cycle: drive at negedge, judge decisions, then the level
    task automatic apply(input logic ev, input logic [5:0] ctl, input logic [7:0] st,
                         input logic [31:0] isel, input logic [31:0] bsel,
                         input logic [31:0] wsel, input logic ack);
        logic w_e, b_e, i_e;
        string tag;
        @(negedge clk_i);
        check(irq_o, irq_exp, "R9", "irq level");
        eval_i = ev; ctl_i = ctl; dev_stat_i = st;
        irq_sel_i = isel; br_sel_i = bsel; wait_sel_i = wsel; irq_ack_i = ack;
        // R1 field placement, R5 each field paired with its own select
        w_e = ev && pol_of(ctl[1:0], cond_of(st, wsel));
        b_e = ev && !w_e && pol_of(ctl[3:2], cond_of(st, bsel));
        i_e = ev && !w_e && pol_of(ctl[5:4], cond_of(st, isel));
        if (!ev) tag = "R7";
        else if (w_e && (ctl[3:2] != 0 || ctl[5:4] != 0)) tag = "R8";
        else if (isel[19:16] == 0 || bsel[19:16] == 0 || wsel[19:16] == 0) tag = "R6";
        else tag = "R5";
        #1;
        check(wait_o, w_e, tag, "wait");
        check(branch_o, b_e, tag, "branch");
        check(irq_take_o, i_e, tag, "irq verdict");
        // R10: request wins over acknowledge
        if (i_e) irq_exp = 1'b1;
        else if (ack) irq_exp = 1'b0;
    endtask

    initial begin
        #2;
        check(irq_o, 1'b0, "R11", "irq in reset");
        repeat (3) @(posedge clk_i);
        #2;
        check(irq_o, 1'b0, "R11", "irq in reset");
        rst_ni = 1'b1;
        for (int s = 0; s < 16; s++) begin
            for (int c = 0; c < 64; c++) begin
                for (int d = 0; d < 16; d++) begin
                    logic [31:0] junk, isel, bsel, wsel;
                    logic [7:0]  st;
                    logic        ev, ack;
                    // R3: bits outside the fields carry noise
                    junk = 32'hA5A0_5AF0 ^ {s[3:0], 12'h0, c[3:0], d[3:0], 8'h0};
                    junk = junk & ~32'h000F_000F;
                    isel = junk | {12'h0, s[3:0], 12'h0, 4'(s + 1)};
                    bsel = junk | {12'h0, 4'(s * 5), 12'h0, 4'(s + 7)};
                    wsel = junk | {12'h0, 4'(s ^ 4'h9), 12'h0, 4'(s * 3)};
                    // R4: upper status bits are noise
                    st   = {4'(c + s), d[3:0]};
                    ev   = ((c + d + s) % 7) != 0;
                    ack  = (d[0] ^ s[1]) && c[1];
                    apply(ev, c[5:0], st, isel, bsel, wsel, ack);
                end
            end
        end
        @(negedge clk_i);
        check(irq_o, irq_exp, "R9", "irq level");
        eval_i = 1'b0; irq_ack_i = 1'b1;
        @(negedge clk_i);
        check(irq_o, 1'b0, "R9", "irq cleared by ack");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #1_500_000;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule